// File: doc/BRIEF.md
# Base and Limit Relocation Unit

This block sits between a processor's address generator and the memory port. It relocates and fences user-mode accesses using one base register and one limit register. On each cycle it accepts a logical address, a valid strobe and a privilege flag. In user mode, the logical address is checked against the limit. A legal address is then offset by the base. An illegal address produces a protection fault, and no memory request is issued. In kernel mode the address goes out unchanged.

The two registers are loaded through a small write port, for example while a context switch is in progress. The privilege flag also marks who issued a register write. User-mode writes are refused, and they set a sticky violation flag that only kernel software can clear. All results leave the block from registers, one cycle after the access is presented.

Top module: `base_limit_mmu`

## Requirements
- R1: After a synchronous reset, mem_valid_o, fault_o, mem_addr_o and priv_viol_o are 0. Base and limit are 0, so any user access faults.
- R2: A valid user access with logical address below the limit, and with no carry out of the sum, gives mem_valid_o=1, fault_o=0 and mem_addr_o = base + logical on the cycle after it is presented.
- R3: A valid user access with logical address greater than or equal to the limit gives fault_o=1 and mem_valid_o=0. An address of limit-1 passes, and an address equal to the limit faults.
- R4: A user access whose 32-bit base-plus-address sum carries out of bit 31 faults and is not passed on.
- R5: fault_o and mem_valid_o are never both 1. A cycle without a valid access yields both low and mem_addr_o = 0. mem_addr_o is 0 whenever mem_valid_o is 0.
- R6: A valid kernel access (priv_kernel_i=1) always gives mem_valid_o=1, fault_o=0 and mem_addr_o equal to the logical address, whatever the base and limit.
- R7: A kernel register write loads the base register when cfg_sel_i=0 and the limit register when cfg_sel_i=1. The new value applies to accesses from the following cycle on.
- R8: A register write with priv_kernel_i=0 leaves base and limit unchanged and sets priv_viol_o on the next cycle.
- R9: priv_viol_o stays set until a kernel write with cfg_sel_i=2 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 32 | Logical address |
| priv_kernel_i | input | 1 | 1 = kernel mode, 0 = user mode (applies to accesses and writes) |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | 0 base, 1 limit, 2 clear violation flag |
| cfg_data_i | input | 32 | Register write data |
| mem_valid_o | output | 1 | Memory request issued |
| mem_addr_o | output | 32 | Physical address |
| fault_o | output | 1 | Protection fault |
| priv_viol_o | output | 1 | Sticky user-write violation flag |

## Verification
On every cycle, the assertions check four things. A fault and a request never coincide. A kernel access passes through unchanged. An out-of-range user access faults. A user write leaves both registers untouched and raises the sticky flag, which stays up until it is cleared. Only the bench scenarios can show the translated values themselves. These include the exact physical addresses at the edges of the limit window, the carry-out case near the top of the address space, and the timing of a new base or limit reaching later accesses.

// File: rtl/rlu_pkg.sv
package rlu_pkg;
  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_CLEAR = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/rlu_regs.sv
module rlu_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              kernel,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] data,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] limit_q,
  output logic              viol_q
);
  import rlu_pkg::*;

  logic ok_wr;
  assign ok_wr = wr && kernel;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
      viol_q  <= 1'b0;
    end else begin
      if (ok_wr && sel == SEL_BASE)  base_q  <= data;
      if (ok_wr && sel == SEL_LIMIT) limit_q <= data;
      if (wr && !kernel)             viol_q  <= 1'b1;
      else if (ok_wr && sel == SEL_CLEAR) viol_q <= 1'b0;
    end
  end

  assert_user_write_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && !kernel) |=> ($stable(base_q) && $stable(limit_q)));
  assert_viol_set_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && !kernel) |=> viol_q);
  assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (viol_q && !(wr && kernel && sel == SEL_CLEAR)) |=> viol_q);
endmodule

// File: rtl/rlu_check.sv
module rlu_check #(
  parameter int ADDR_W = 32
) (
  input  logic              valid,
  input  logic              kernel,
  input  logic [ADDR_W-1:0] laddr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              req,
  output logic              flt,
  output logic [ADDR_W-1:0] paddr
);
  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] sum;
  logic in_range, carry;

  always_comb begin
    sum      = {1'b0, base} + {1'b0, laddr};
    in_range = laddr < limit;
    carry    = sum[SUM_W-1];
    if (!valid) begin
      req = 1'b0; flt = 1'b0; paddr = '0;
    end else if (kernel) begin
      req = 1'b1; flt = 1'b0; paddr = laddr;
    end else if (in_range && !carry) begin
      req = 1'b1; flt = 1'b0; paddr = sum[ADDR_W-1:0];
    end else begin
      req = 1'b0; flt = 1'b1; paddr = '0;
    end
  end
endmodule

// File: rtl/rlu_outreg.sv
module rlu_outreg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_d,
  input  logic              flt_d,
  input  logic [ADDR_W-1:0] addr_d,
  output logic              req_q,
  output logic              flt_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      flt_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q  <= req_d;
      flt_q  <= flt_d;
      addr_q <= addr_d;
    end
  end

  assert_req_fault_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(req_q && flt_q));
endmodule

// File: rtl/base_limit_mmu.sv
module base_limit_mmu #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              priv_kernel_i,
  input  logic              cfg_wr_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              fault_o,
  output logic              priv_viol_o
);
  logic [ADDR_W-1:0] base_q, limit_q, paddr_d;
  logic req_d, flt_d;

  rlu_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr_i), .kernel(priv_kernel_i),
    .sel(cfg_sel_i), .data(cfg_data_i),
    .base_q(base_q), .limit_q(limit_q), .viol_q(priv_viol_o)
  );

  rlu_check #(.ADDR_W(ADDR_W)) u_check (
    .valid(acc_valid_i), .kernel(priv_kernel_i), .laddr(acc_addr_i),
    .base(base_q), .limit(limit_q),
    .req(req_d), .flt(flt_d), .paddr(paddr_d)
  );

  rlu_outreg #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .req_d(req_d), .flt_d(flt_d), .addr_d(paddr_d),
    .req_q(mem_valid_o), .flt_q(fault_o), .addr_q(mem_addr_o)
  );

  assert_kernel_passthru_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && priv_kernel_i) |=>
      (mem_valid_o && !fault_o && mem_addr_o == $past(acc_addr_i)));
  assert_out_of_range_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && !priv_kernel_i && acc_addr_i >= limit_q) |=>
      (fault_o && !mem_valid_o));
endmodule

// File: tb/base_limit_mmu_bench.sv
module base_limit_mmu_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid_i = 1'b0, priv_kernel_i = 1'b0, cfg_wr_i = 1'b0;
  logic [31:0] acc_addr_i = '0, cfg_data_i = '0;
  logic [1:0] cfg_sel_i = '0;
  logic mem_valid_o, fault_o, priv_viol_o;
  logic [31:0] mem_addr_o;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  base_limit_mmu u_base_limit_mmu (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic kern, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    priv_kernel_i = kern; cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d;
    @(negedge clk);
    cfg_wr_i = 1'b0; priv_kernel_i = 1'b0;
  endtask

  task automatic access(input string req, input logic kern, input logic vld, input logic [31:0] a,
                        input logic ev, input logic [31:0] ea, input logic ef);
    @(negedge clk);
    acc_valid_i = vld; priv_kernel_i = kern; acc_addr_i = a;
    @(posedge clk); #1;
    chk({req, " valid"}, {31'b0, mem_valid_o}, {31'b0, ev});
    chk({req, " addr"}, mem_addr_o, ea);
    chk({req, " fault"}, {31'b0, fault_o}, {31'b0, ef});
    acc_valid_i = 1'b0; priv_kernel_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", {31'b0, mem_valid_o}, 0);
    chk("R1 fault", {31'b0, fault_o}, 0);
    chk("R1 addr", mem_addr_o, 0);
    chk("R1 viol", {31'b0, priv_viol_o}, 0);
    access("R1 user access faults", 1'b0, 1'b1, 32'h0, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic t_translate;
    cfg_write(1'b1, 2'd0, 32'h0002_0000);
    cfg_write(1'b1, 2'd1, 32'h0001_0000);
    access("R7 R2 low", 1'b0, 1'b1, 32'h0, 1'b1, 32'h0002_0000, 1'b0);
    access("R2 mid", 1'b0, 1'b1, 32'h1234, 1'b1, 32'h0002_1234, 1'b0);
    access("R3 limit-1", 1'b0, 1'b1, 32'hFFFF, 1'b1, 32'h0002_FFFF, 1'b0);
    access("R3 at limit", 1'b0, 1'b1, 32'h1_0000, 1'b0, 32'h0, 1'b1);
    access("R3 far", 1'b0, 1'b1, 32'h8000_0000, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic t_carry;
    cfg_write(1'b1, 2'd0, 32'hFFFF_F000);
    cfg_write(1'b1, 2'd1, 32'hFFFF_FFFF);
    access("R4 top fits", 1'b0, 1'b1, 32'hFFF, 1'b1, 32'hFFFF_FFFF, 1'b0);
    access("R4 carry", 1'b0, 1'b1, 32'h1000, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic t_kernel_idle;
    access("R6 kernel pass", 1'b1, 1'b1, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, 1'b0);
    access("R5 idle", 1'b0, 1'b0, 32'h0000_0040, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_user_write;
    cfg_write(1'b1, 2'd0, 32'h0000_1000);
    cfg_write(1'b1, 2'd1, 32'h0000_0100);
    cfg_write(1'b0, 2'd0, 32'h0050_0000);
    chk("R8 viol set", {31'b0, priv_viol_o}, 1);
    cfg_write(1'b0, 2'd1, 32'hFFFF_FFFF);
    access("R8 base kept", 1'b0, 1'b1, 32'h10, 1'b1, 32'h0000_1010, 1'b0);
    access("R8 limit kept", 1'b0, 1'b1, 32'h100, 1'b0, 32'h0, 1'b1);
    cfg_write(1'b1, 2'd0, 32'h0000_2000);
    chk("R9 viol sticky", {31'b0, priv_viol_o}, 1);
    cfg_write(1'b0, 2'd2, 32'h0);
    chk("R9 user clear ignored", {31'b0, priv_viol_o}, 1);
    cfg_write(1'b1, 2'd2, 32'h0);
    chk("R9 viol cleared", {31'b0, priv_viol_o}, 0);
    access("R7 new base", 1'b0, 1'b1, 32'h20, 1'b1, 32'h0000_2020, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_translate();
    t_carry();
    t_kernel_idle();
    t_user_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule